// File: doc/BRIEF.md
# System Clock to Sample Rate Ratio Detector

This block counts system clock cycles between successive rising edges of an already synchronised word select line. It then decides which of six oversampling ratios the audio front end is running at. The clock and word select both come from outside and are frequency-locked, so a valid setup gives an exact whole count per sample period. A small window around each nominal count absorbs edge jitter.

The result is a three-bit mode code, a locked flag and an error flag. Interpolation and modulation stages downstream use the mode code only while the locked flag is high. A low-sample-rate input removes the two fastest ratios from the accepted set. Lock is gained and lost with hysteresis, and the mode code keeps its last locked value while a new lock is being acquired. If the word select line goes quiet, a watchdog drops the lock.

Top module: `clkratio_detect`

## Requirements
- R1: While the synchronous active-high reset is asserted, and on the cycle after it is released, `mode_o` is 7 (no mode), `locked_o` is 0 and `ratio_err_o` is 0.
- R2: A measurement is the number of clock cycles from one rising edge of `ws_i` to the next. Mode codes are 0 for 128, 1 for 192, 2 for 256, 3 for 384, 4 for 512 and 5 for 768 clocks per period.
- R3: A measurement within 2 cycles of a nominal ratio, bounds included, matches that ratio. A measurement 3 cycles away matches no ratio.
- R4: The detector locks on the fourth consecutive measurement of the same ratio. Three consecutive measurements do not lock it.
- R5: A measurement that matches no allowed ratio sets `ratio_err_o` and clears `locked_o` in the same update. The error flag stays set until the next matching measurement clears it.
- R6: While locked, a single measurement of a different supported ratio leaves the lock in place. A second consecutive such measurement clears `locked_o`.
- R7: `mode_o` changes only at the update that sets `locked_o`. It holds its last locked value while unlocked and while lock is reacquired.
- R8: With `low_rate_i` at 1, measurements of 128 or 192 count as unsupported. 256, 384, 512 and 768 are still accepted.
- R9: If 1024 clock cycles pass with no rising edge of `ws_i`, `locked_o` is cleared. `mode_o` keeps its value.
- R10: The first rising edge of `ws_i` after reset or after a timeout only starts a measurement. It produces no classification, so it cannot raise the error flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ws_i | input | 1 | Word select, already synchronised to `clk` |
| low_rate_i | input | 1 | Low-sample-rate mode; removes ratios 128 and 192 |
| mode_o | output | 3 | Detected ratio code (0..5), 7 before the first lock |
| locked_o | output | 1 | Ratio stable and valid |
| ratio_err_o | output | 1 | Last measurement matched no allowed ratio |

## Verification
The bench sends periods that sit exactly on the tolerance edges (126, 130) and just past them (131). A comparator that is off by one in either direction either flags an error on a legal clock or accepts an illegal one. Separate sequences check the lock thresholds: a detector that locks after three periods, or unlocks on the first odd period, shows the wrong flag at a point where the bench has a fixed expectation. Other cases check that the held mode does not move while a new ratio is being learned, and that low-rate mode rejects 192. A design that kept an unsupported ratio would stay locked. The last checks cover silence on the word select line past the timeout, and the edge that follows it. A design that measured across that gap would raise a false error.

// File: rtl/clkratio_pkg.sv
package clkratio_pkg;

  localparam int NUM_MODES = 6;
  localparam int CODE_W    = 3;
  localparam logic [CODE_W-1:0] CODE_NONE = 3'd7;

  // Nominal system clocks per sample period, indexed by mode code.
  function automatic int unsigned nominal_ratio(input int idx);
    case (idx)
      0:       return 128;
      1:       return 192;
      2:       return 256;
      3:       return 384;
      4:       return 512;
      5:       return 768;
      default: return 0;
    endcase
  endfunction

  // Low-rate operation excludes the two fastest ratios.
  function automatic logic mode_allowed(input int idx, input logic low_rate);
    return !(low_rate && (idx < 2));
  endfunction

endpackage

// File: rtl/clkratio_ws_timer.sv
module clkratio_ws_timer #(
  parameter int TIMEOUT = 1024,
  parameter int CNT_W   = $clog2(TIMEOUT + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ws_i,
  output logic             meas_vld_o,
  output logic [CNT_W-1:0] meas_len_o,
  output logic             tmo_o
);

  localparam logic [CNT_W-1:0] LIMIT     = CNT_W'(TIMEOUT);
  localparam logic [CNT_W-1:0] LIMIT_M1  = CNT_W'(TIMEOUT - 1);
  localparam logic [CNT_W-1:0] CNT_ONE   = CNT_W'(1);

  logic             ws_q;
  logic             armed_q;
  logic [CNT_W-1:0] cnt_q;
  logic             rise;

  assign rise = ws_i & ~ws_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ws_q       <= 1'b0;
      armed_q    <= 1'b0;
      cnt_q      <= '0;
      meas_vld_o <= 1'b0;
      meas_len_o <= '0;
      tmo_o      <= 1'b0;
    end else begin
      ws_q       <= ws_i;
      meas_vld_o <= rise & armed_q;
      tmo_o      <= ~rise & armed_q & (cnt_q == LIMIT_M1);
      if (rise) begin
        meas_len_o <= cnt_q;
        cnt_q      <= CNT_ONE;
        armed_q    <= 1'b1;
      end else begin
        if (cnt_q != LIMIT) begin
          cnt_q <= cnt_q + CNT_ONE;
        end
        if (cnt_q == LIMIT_M1) begin
          armed_q <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/clkratio_classify.sv
module clkratio_classify
  import clkratio_pkg::*;
#(
  parameter int CNT_W = 11,
  parameter int TOL   = 2
) (
  input  logic              [CNT_W-1:0] len_i,
  input  logic                          low_rate_i,
  output logic                          hit_o,
  output logic              [CODE_W-1:0] code_o
);

  logic [NUM_MODES-1:0] near;

  for (genvar g = 0; g < NUM_MODES; g++) begin : g_win
    localparam int unsigned NOM = nominal_ratio(g);
    localparam logic [CNT_W-1:0] LO = CNT_W'(NOM - TOL);
    localparam logic [CNT_W-1:0] HI = CNT_W'(NOM + TOL);
    logic in_band;
    assign in_band = (len_i >= LO) && (len_i <= HI);
    assign near[g] = in_band & mode_allowed(g, low_rate_i);
  end

  always_comb begin
    hit_o  = |near;
    code_o = CODE_NONE;
    for (int i = NUM_MODES - 1; i >= 0; i--) begin
      if (near[i]) code_o = CODE_W'(i);
    end
  end

endmodule

// File: rtl/clkratio_lock.sv
module clkratio_lock
  import clkratio_pkg::*;
#(
  parameter int LOCK_N   = 4,
  parameter int UNLOCK_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              meas_vld_i,
  input  logic              hit_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              tmo_i,
  output logic              locked_o,
  output logic [CODE_W-1:0] mode_o,
  output logic              err_o
);

  localparam int MW = $clog2(LOCK_N + 1);
  localparam int UW = $clog2(UNLOCK_N + 1);
  localparam logic [MW-1:0] MATCH_MAX = MW'(LOCK_N);
  localparam logic [UW-1:0] MISS_MAX  = UW'(UNLOCK_N);

  logic [CODE_W-1:0] cand_q;
  logic [MW-1:0]     match_q, match_nx;
  logic [UW-1:0]     miss_q, miss_nx;
  logic              same_cand;

  always_comb begin
    same_cand = (code_i == cand_q) && (match_q != '0);
    if (!same_cand)             match_nx = MW'(1);
    else if (match_q == MATCH_MAX) match_nx = match_q;
    else                        match_nx = match_q + MW'(1);

    if (code_i == mode_o)       miss_nx = '0;
    else if (miss_q == MISS_MAX) miss_nx = miss_q;
    else                        miss_nx = miss_q + UW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cand_q   <= CODE_NONE;
      match_q  <= '0;
      miss_q   <= '0;
      locked_o <= 1'b0;
      mode_o   <= CODE_NONE;
      err_o    <= 1'b0;
    end else if (tmo_i) begin
      locked_o <= 1'b0;
      match_q  <= '0;
      miss_q   <= '0;
    end else if (meas_vld_i) begin
      if (!hit_i) begin
        err_o    <= 1'b1;
        locked_o <= 1'b0;
        match_q  <= '0;
        miss_q   <= '0;
      end else begin
        err_o   <= 1'b0;
        cand_q  <= code_i;
        match_q <= match_nx;
        if (locked_o) begin
          miss_q <= miss_nx;
          if (miss_nx >= MISS_MAX) begin
            locked_o <= 1'b0;
            miss_q   <= '0;
          end
        end else if (match_nx >= MATCH_MAX) begin
          locked_o <= 1'b1;
          mode_o   <= code_i;
          miss_q   <= '0;
        end
      end
    end
  end

endmodule

// File: rtl/clkratio_detect.sv
module clkratio_detect
  import clkratio_pkg::*;
#(
  parameter int TOL      = 2,
  parameter int LOCK_N   = 4,
  parameter int UNLOCK_N = 2,
  parameter int TIMEOUT  = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ws_i,
  input  logic              low_rate_i,
  output logic [CODE_W-1:0] mode_o,
  output logic              locked_o,
  output logic              ratio_err_o
);

  localparam int CNT_W = $clog2(TIMEOUT + 1);

  logic             meas_vld;
  logic [CNT_W-1:0] meas_len;
  logic             tmo;
  logic             hit;
  logic [CODE_W-1:0] code;

  clkratio_ws_timer #(
    .TIMEOUT (TIMEOUT),
    .CNT_W   (CNT_W)
  ) u_timer (
    .clk        (clk),
    .rst        (rst),
    .ws_i       (ws_i),
    .meas_vld_o (meas_vld),
    .meas_len_o (meas_len),
    .tmo_o      (tmo)
  );

  clkratio_classify #(
    .CNT_W (CNT_W),
    .TOL   (TOL)
  ) u_class (
    .len_i      (meas_len),
    .low_rate_i (low_rate_i),
    .hit_o      (hit),
    .code_o     (code)
  );

  clkratio_lock #(
    .LOCK_N   (LOCK_N),
    .UNLOCK_N (UNLOCK_N)
  ) u_lock (
    .clk        (clk),
    .rst        (rst),
    .meas_vld_i (meas_vld),
    .hit_i      (hit),
    .code_i     (code),
    .tmo_i      (tmo),
    .locked_o   (locked_o),
    .mode_o     (mode_o),
    .err_o      (ratio_err_o)
  );

endmodule

// File: rtl/clkratio_detect_chk.sv
module clkratio_detect_chk #(
  parameter int TIMEOUT = 1024
) (
  input logic       clk,
  input logic       rst,
  input logic       ws_i,
  input logic       low_rate_i,
  input logic [2:0] mode_o,
  input logic       locked_o,
  input logic       ratio_err_o
);

  localparam int IW = $clog2(TIMEOUT + 16);
  localparam logic [IW-1:0] IDLE_MAX  = IW'(TIMEOUT + 8);
  localparam logic [IW-1:0] IDLE_LIM  = IW'(TIMEOUT + 2);

  logic          ws_d;
  logic [IW-1:0] idle_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ws_d   <= 1'b0;
      idle_q <= '0;
    end else begin
      ws_d <= ws_i;
      if (ws_i & ~ws_d)          idle_q <= '0;
      else if (idle_q != IDLE_MAX) idle_q <= idle_q + IW'(1);
    end
  end

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mode_o == 3'd7 && !locked_o && !ratio_err_o)); // R1

  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (mode_o <= 3'd5) || (mode_o == 3'd7)); // R2

  AST_ERR_NOT_LOCKED: assert property (@(posedge clk) disable iff (rst)
    ratio_err_o |-> !locked_o); // R5

  AST_MODE_ON_LOCK_ONLY: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && mode_o != $past(mode_o)) |-> $rose(locked_o)); // R7

  AST_LOW_RATE_MODE: assert property (@(posedge clk) disable iff (rst)
    ($rose(locked_o) && $past(low_rate_i)) |-> (mode_o >= 3'd2)); // R8

  AST_IDLE_UNLOCK: assert property (@(posedge clk) disable iff (rst)
    (idle_q >= IDLE_LIM) |-> !locked_o); // R9

endmodule

bind clkratio_detect clkratio_detect_chk #(.TIMEOUT(TIMEOUT)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .ws_i        (ws_i),
  .low_rate_i  (low_rate_i),
  .mode_o      (mode_o),
  .locked_o    (locked_o),
  .ratio_err_o (ratio_err_o)
);

// File: tb/clkratio_detect_tb.sv
module clkratio_detect_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ws  = 1'b0;
  logic       lr  = 1'b0;
  logic [2:0] mode;
  logic       locked;
  logic       err;

  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  clkratio_detect u_dut (
    .clk         (clk),
    .rst         (rst),
    .ws_i        (ws),
    .low_rate_i  (lr),
    .mode_o      (mode),
    .locked_o    (locked),
    .ratio_err_o (err)
  );

  // {ratio[10:0], periods[3:0], low_rate, exp_locked, exp_mode[2:0], exp_err, req[3:0]}
  localparam int NV = 18;
  localparam logic [24:0] VEC [NV] = '{
    {11'd256, 4'd4, 1'b0, 1'b0, 3'd7, 1'b0, 4'd4},  // R4 three measurements, R10 first edge
    {11'd256, 4'd1, 1'b0, 1'b1, 3'd2, 1'b0, 4'd2},  // R2 fourth 256 locks
    {11'd384, 4'd1, 1'b0, 1'b1, 3'd2, 1'b0, 4'd6},  // R6 still measuring 256
    {11'd384, 4'd1, 1'b0, 1'b1, 3'd2, 1'b0, 4'd6},  // R6 one mismatch tolerated
    {11'd384, 4'd1, 1'b0, 1'b0, 3'd2, 1'b0, 4'd7},  // R7 dropped, mode held
    {11'd384, 4'd2, 1'b0, 1'b1, 3'd3, 1'b0, 4'd7},  // R7 relock to 384
    {11'd130, 4'd1, 1'b0, 1'b1, 3'd3, 1'b0, 4'd6},
    {11'd130, 4'd3, 1'b0, 1'b0, 3'd3, 1'b0, 4'd6},
    {11'd126, 4'd1, 1'b0, 1'b1, 3'd0, 1'b0, 4'd3},  // R3 +2 accepted
    {11'd126, 4'd4, 1'b0, 1'b1, 3'd0, 1'b0, 4'd3},  // R3 -2 accepted
    {11'd131, 4'd1, 1'b0, 1'b1, 3'd0, 1'b0, 4'd3},
    {11'd128, 4'd1, 1'b0, 1'b0, 3'd0, 1'b1, 4'd5},  // R5 131 rejected
    {11'd192, 4'd1, 1'b0, 1'b0, 3'd0, 1'b0, 4'd5},  // R5 error cleared
    {11'd192, 4'd4, 1'b0, 1'b1, 3'd1, 1'b0, 4'd2},
    {11'd512, 4'd1, 1'b1, 1'b0, 3'd1, 1'b1, 4'd8},  // R8 192 rejected in low rate
    {11'd512, 4'd4, 1'b1, 1'b1, 3'd4, 1'b0, 4'd8},
    {11'd768, 4'd5, 1'b1, 1'b1, 3'd5, 1'b0, 4'd2},
    {11'd256, 4'd5, 1'b1, 1'b1, 3'd2, 1'b0, 4'd8}
  };

  task automatic chk(input string rq, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic drive_period(input int ratio);
    for (int k = 0; k < ratio; k++) begin
      ws = (k < ratio / 2);
      @(negedge clk);
    end
    ws = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d cycles", cycles, 150000);
        finish_run();
      end
    end
  end

  initial begin
    idle(5);
    // R1 while reset is held
    chk("R1", "mode in reset", int'(mode), 7);
    rst = 1'b0;
    @(negedge clk);
    // R1 after release
    chk("R1", "mode", int'(mode), 7);
    chk("R1", "locked", int'(locked), 0);
    chk("R1", "err", int'(err), 0);

    for (int v = 0; v < NV; v++) begin
      logic [24:0] e;
      string rq;
      e  = VEC[v];
      lr = e[9];
      for (int p = 0; p < int'(e[13:10]); p++) drive_period(int'(e[24:14]));
      rq = $sformatf("R%0d", int'(e[3:0]));
      chk(rq, $sformatf("vec%0d locked", v), int'(locked), int'(e[8]));
      chk(rq, $sformatf("vec%0d mode", v),   int'(mode),   int'(e[7:5]));
      chk(rq, $sformatf("vec%0d err", v),    int'(err),    int'(e[4]));
    end

    // R9: still locked well inside the window, cleared after it
    idle(600);
    chk("R9", "locked before timeout", int'(locked), 1);
    idle(300);
    chk("R9", "locked after timeout", int'(locked), 0);
    chk("R9", "mode held after timeout", int'(mode), 2);
    chk("R9", "err after timeout", int'(err), 0);

    // R10: the first edge after a timeout is not classified
    drive_period(256);
    chk("R10", "err after restart edge", int'(err), 0);
    chk("R10", "locked after restart edge", int'(locked), 0);
    for (int p = 0; p < 4; p++) drive_period(256);
    chk("R10", "relock after restart", int'(locked), 1);
    chk("R10", "mode after relock", int'(mode), 2);

    // R1: reset from a locked state
    rst = 1'b1;
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "mode after mid reset", int'(mode), 7);
    chk("R1", "locked after mid reset", int'(locked), 0);
    chk("R1", "err after mid reset", int'(err), 0);

    finish_run();
  end

endmodule